// File: doc/BRIEF.md
# Scan Test Port with Sampling and Output-Float Instructions

This block is a serial test port of the familiar four-wire kind (test clock, mode select, data in, data out). A sixteen-state controller steps on the mode-select line; a 3-bit instruction register picks which data register is placed between data in and data out. The data registers are a one-bit bypass cell, a 32-bit identification word and a 70-cell boundary register. The boundary register can only capture the parallel bus of pin states. It never drives pins.

Two instructions, the all-zeros code and the float-while-sampling code, raise an output-disable line to the core for as long as they are loaded. Both still capture pin states like a plain sample. There is no test-reset pin. An active-low power-on reset input puts the port into the reset state, and five rising clock edges with mode-select high do the same from any state.

Controller states (named here and in the RTL): TS_RESET, TS_IDLE, TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EX1, TS_DR_PAUSE, TS_DR_EX2, TS_DR_UPD, TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EX1, TS_IR_PAUSE, TS_IR_EX2, TS_IR_UPD.

Transitions on a rising edge, written as (TMS=0 / TMS=1):

| State | TMS=0 | TMS=1 |
|---|---|---|
| TS_RESET | TS_IDLE | TS_RESET |
| TS_IDLE | TS_IDLE | TS_DR_SEL |
| TS_DR_SEL | TS_DR_CAP | TS_IR_SEL |
| TS_DR_CAP / TS_DR_SHIFT | TS_DR_SHIFT | TS_DR_EX1 |
| TS_DR_EX1 | TS_DR_PAUSE | TS_DR_UPD |
| TS_DR_PAUSE | TS_DR_PAUSE | TS_DR_EX2 |
| TS_DR_EX2 | TS_DR_SHIFT | TS_DR_UPD |
| TS_DR_UPD / TS_IR_UPD | TS_IDLE | TS_DR_SEL |
| TS_IR_SEL | TS_IR_CAP | TS_RESET |
| TS_IR_CAP / TS_IR_SHIFT | TS_IR_SHIFT | TS_IR_EX1 |
| TS_IR_EX1 | TS_IR_PAUSE | TS_IR_UPD |
| TS_IR_PAUSE | TS_IR_PAUSE | TS_IR_EX2 |
| TS_IR_EX2 | TS_IR_SHIFT | TS_IR_UPD |

Top module: `tap_port`

## Requirements
- R1: The controller follows the transition table above on each rising edge of `tck`. A low `por_n` puts it into TS_RESET at once.
- R2: From any state, five consecutive rising edges with `tms` high reach TS_RESET. At power-on, and at each rising edge spent in TS_RESET, the instruction register is loaded with the identification code 001. This also drops `core_hiz`.
- R3: The instruction register is 3 bits wide. In TS_IR_CAP its shift stage is loaded with 001, so the first three bits shifted out are 1, 0, 0. A shifted instruction takes effect only at the rising edge that leaves TS_IR_UPD. Until then the previous instruction stays in force.
- R4: The codes select data registers as follows. 001 selects the identification word. 000, 010 and 100 select the boundary register. 111 selects bypass. The reserved codes 011, 101 and 110 select bypass and have no other effect.
- R5: `core_hiz` is high exactly while the loaded instruction is 000 or 010, and low under every other code.
- R6: The bypass register is one cell long and captures 0 in TS_DR_CAP.
- R7: The identification word is 32 bits and shifts out bit 0 first. Its layout is: bit 0 = 1; bits 11:1 manufacturer field (default 11'h15A); bits 17:12 = 0; bits 22:18 width field (default 5); bits 27:23 depth field (default 4); bits 31:28 revision (default 2).
- R8: The boundary register is BSR_LEN cells long (default 70). In TS_DR_CAP, cell i captures `pin_state[i]`, except the placeholder cells set in PH_MASK (default indices 36 and 51), which capture 1. Cell 0 is nearest `tdo` and leaves first.
- R9: TS_DR_UPD changes nothing under any instruction. There is no preload, and `core_hiz` keeps its value.
- R10: `tdo` and `tdo_en` change only on the falling edge of `tck`. `tdo_en` is high only in TS_IR_SHIFT and TS_DR_SHIFT, and `tdo` is 0 while disabled.
- R11: In a shift state, each rising edge moves the selected register one cell toward `tdo`, and `tdi` enters the far end. So a pattern fed in appears on `tdo` after exactly the register's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| tms | input | 1 | Mode select, sampled on the rising edge |
| tdi | input | 1 | Serial data in, sampled on the rising edge |
| pin_state | input | BSR_LEN | Parallel states of the observed pins |
| tdo | output | 1 | Serial data out, updated on the falling edge |
| tdo_en | output | 1 | Drive enable for `tdo` |
| core_hiz | output | 1 | Forces the functional outputs to high impedance |

## Verification
Two functions can meet on one edge. Reaching TS_RESET by five high `tms` edges can fall while a float instruction holds `core_hiz` high. The bench provokes this by loading code 010, entering a shift and then holding `tms` high. It judges that `core_hiz` drops after the first edge spent in reset, and that a later data read returns the identification word. The other meeting point is Update-IR, where the new code lands while its effect on `core_hiz` and on register selection must not show before the edge that leaves TS_IR_UPD. The bench samples `core_hiz` in TS_IR_UPD and again after that edge. A long pseudo-random `tms` walk covers all 32 controller arcs against an arithmetic model of the table.

// File: rtl/tap_pkg.sv
package tap_pkg;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_DR_SEL, TS_DR_CAP, TS_DR_SHIFT, TS_DR_EX1, TS_DR_PAUSE, TS_DR_EX2, TS_DR_UPD,
        TS_IR_SEL, TS_IR_CAP, TS_IR_SHIFT, TS_IR_EX1, TS_IR_PAUSE, TS_IR_EX2, TS_IR_UPD
    } tap_state_t;

    localparam int IR_W = 3;

    localparam logic [IR_W-1:0] OP_ZERO_HIZ = 3'b000;
    localparam logic [IR_W-1:0] OP_IDCODE   = 3'b001;
    localparam logic [IR_W-1:0] OP_SAMPLE_Z = 3'b010;
    localparam logic [IR_W-1:0] OP_SAMPLE   = 3'b100;
    localparam logic [IR_W-1:0] OP_BYPASS   = 3'b111;
    localparam logic [IR_W-1:0] IR_CAPTURE  = 3'b001;

    typedef enum logic [1:0] {
        SEL_BYPASS,
        SEL_ID,
        SEL_BSR
    } dr_sel_t;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import tap_pkg::*;
(
    input  logic       tck,
    input  logic       por_n,
    input  logic       tms,
    output tap_state_t state_o
);

    tap_state_t st_q;
    tap_state_t st_d;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) st_q <= TS_RESET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            TS_RESET:    st_d = tms ? TS_RESET    : TS_IDLE;
            TS_IDLE:     st_d = tms ? TS_DR_SEL   : TS_IDLE;
            TS_DR_SEL:   st_d = tms ? TS_IR_SEL   : TS_DR_CAP;
            TS_DR_CAP:   st_d = tms ? TS_DR_EX1   : TS_DR_SHIFT;
            TS_DR_SHIFT: st_d = tms ? TS_DR_EX1   : TS_DR_SHIFT;
            TS_DR_EX1:   st_d = tms ? TS_DR_UPD   : TS_DR_PAUSE;
            TS_DR_PAUSE: st_d = tms ? TS_DR_EX2   : TS_DR_PAUSE;
            TS_DR_EX2:   st_d = tms ? TS_DR_UPD   : TS_DR_SHIFT;
            TS_DR_UPD:   st_d = tms ? TS_DR_SEL   : TS_IDLE;
            TS_IR_SEL:   st_d = tms ? TS_RESET    : TS_IR_CAP;
            TS_IR_CAP:   st_d = tms ? TS_IR_EX1   : TS_IR_SHIFT;
            TS_IR_SHIFT: st_d = tms ? TS_IR_EX1   : TS_IR_SHIFT;
            TS_IR_EX1:   st_d = tms ? TS_IR_UPD   : TS_IR_PAUSE;
            TS_IR_PAUSE: st_d = tms ? TS_IR_EX2   : TS_IR_PAUSE;
            TS_IR_EX2:   st_d = tms ? TS_IR_UPD   : TS_IR_SHIFT;
            TS_IR_UPD:   st_d = tms ? TS_DR_SEL   : TS_IDLE;
        endcase
    end

    assign state_o = st_q;

    // run of consecutive high mode-select edges, saturating, for checking only
    logic [2:0] hi_run_q;
    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n)               hi_run_q <= '0;
        else if (!tms)            hi_run_q <= '0;
        else if (hi_run_q != 3'd7) hi_run_q <= hi_run_q + 3'd1;
    end

    // R2: five high edges always land in reset
    a_r2_five_high_reset: assert property (@(posedge tck) disable iff (!por_n)
        (hi_run_q >= 3'd5) |-> (st_q == TS_RESET));

    // R1: leaving capture with tms low enters the shift state
    a_r1_cap_to_shift: assert property (@(posedge tck) disable iff (!por_n)
        (st_q == TS_DR_CAP && !tms) |=> (st_q == TS_DR_SHIFT));

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import tap_pkg::*;
(
    input  logic            tck,
    input  logic            por_n,
    input  tap_state_t      state_i,
    input  logic            tdi,
    output logic [IR_W-1:0] ir_o,
    output logic            sh_lsb_o
);

    logic [IR_W-1:0] sh_q;
    logic [IR_W-1:0] ir_q;

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            sh_q <= IR_CAPTURE;
            ir_q <= OP_IDCODE;
        end else begin
            if (state_i == TS_IR_CAP)        sh_q <= IR_CAPTURE;
            else if (state_i == TS_IR_SHIFT) sh_q <= {tdi, sh_q[IR_W-1:1]};

            if (state_i == TS_RESET)         ir_q <= OP_IDCODE;
            else if (state_i == TS_IR_UPD)   ir_q <= sh_q;
        end
    end

    assign ir_o     = ir_q;
    assign sh_lsb_o = sh_q[0];

    // R3: the active instruction moves only when update or reset is left
    a_r3_update_only: assert property (@(posedge tck) disable iff (!por_n)
        (state_i != TS_IR_UPD && state_i != TS_RESET) |=> $stable(ir_q));

    // R2: an edge in reset leaves the identification code loaded
    a_r2_reset_loads_id: assert property (@(posedge tck) disable iff (!por_n)
        (state_i == TS_RESET) |=> (ir_q == OP_IDCODE));

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import tap_pkg::*;
#(
    parameter int                 BSR_LEN  = 70,
    parameter logic [BSR_LEN-1:0] PH_MASK  = '0,
    parameter logic [31:0]        ID_VALUE = 32'h1
) (
    input  logic               tck,
    input  logic               por_n,
    input  tap_state_t         state_i,
    input  dr_sel_t            sel_i,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pins_i,
    output logic               lsb_o
);

    logic               byp_q;
    logic [31:0]        id_q;
    logic [BSR_LEN-1:0] bsr_q;
    logic [BSR_LEN-1:0] bsr_cap;

    // placeholder cells read a constant 1, the rest follow their pin
    for (genvar gi = 0; gi < BSR_LEN; gi++) begin : g_cell
        if (PH_MASK[gi]) begin : g_ph
            assign bsr_cap[gi] = 1'b1;
        end else begin : g_pin
            assign bsr_cap[gi] = pins_i[gi];
        end
    end

    always_ff @(posedge tck or negedge por_n) begin
        if (!por_n) begin
            byp_q <= 1'b0;
            id_q  <= ID_VALUE;
            bsr_q <= '0;
        end else if (state_i == TS_DR_CAP) begin
            case (sel_i)
                SEL_ID:  id_q  <= ID_VALUE;
                SEL_BSR: bsr_q <= bsr_cap;
                default: byp_q <= 1'b0;
            endcase
        end else if (state_i == TS_DR_SHIFT) begin
            case (sel_i)
                SEL_ID:  id_q  <= {tdi, id_q[31:1]};
                SEL_BSR: bsr_q <= {tdi, bsr_q[BSR_LEN-1:1]};
                default: byp_q <= tdi;
            endcase
        end
    end

    always_comb begin
        case (sel_i)
            SEL_ID:  lsb_o = id_q[0];
            SEL_BSR: lsb_o = bsr_q[0];
            default: lsb_o = byp_q;
        endcase
    end

    // R8: placeholder cells hold 1 right after a boundary capture
    a_r8_placeholder_one: assert property (@(posedge tck) disable iff (!por_n)
        (state_i == TS_DR_CAP && sel_i == SEL_BSR) |=> ((bsr_q & PH_MASK) == PH_MASK));

    // R6: bypass capture yields 0
    a_r6_bypass_zero: assert property (@(posedge tck) disable iff (!por_n)
        (state_i == TS_DR_CAP && sel_i == SEL_BYPASS) |=> (byp_q == 1'b0));

    // R9: update-DR leaves the boundary register untouched
    a_r9_upd_quiet: assert property (@(posedge tck) disable iff (!por_n)
        (state_i == TS_DR_UPD) |=> $stable(bsr_q));

endmodule

// File: rtl/tap_port.sv
module tap_port
    import tap_pkg::*;
#(
    parameter int                 BSR_LEN    = 70,
    parameter logic [BSR_LEN-1:0] PH_MASK    = (BSR_LEN'(1) << 36) | (BSR_LEN'(1) << 51),
    parameter logic [10:0]        MFR_CODE   = 11'h15A,
    parameter logic [4:0]         WIDTH_CODE = 5'd5,
    parameter logic [4:0]         DEPTH_CODE = 5'd4,
    parameter logic [3:0]         REV_CODE   = 4'd2
) (
    input  logic               tck,
    input  logic               por_n,
    input  logic               tms,
    input  logic               tdi,
    input  logic [BSR_LEN-1:0] pin_state,
    output logic               tdo,
    output logic               tdo_en,
    output logic               core_hiz
);

    localparam logic [31:0] ID_VALUE = {REV_CODE, DEPTH_CODE, WIDTH_CODE, 6'b0, MFR_CODE, 1'b1};

    tap_state_t      st;
    logic [IR_W-1:0] ir;
    logic            ir_lsb;
    logic            dr_lsb;
    dr_sel_t         sel;

    tap_fsm u_fsm (
        .tck     (tck),
        .por_n   (por_n),
        .tms     (tms),
        .state_o (st)
    );

    tap_ir u_ir (
        .tck      (tck),
        .por_n    (por_n),
        .state_i  (st),
        .tdi      (tdi),
        .ir_o     (ir),
        .sh_lsb_o (ir_lsb)
    );

    tap_dr #(
        .BSR_LEN  (BSR_LEN),
        .PH_MASK  (PH_MASK),
        .ID_VALUE (ID_VALUE)
    ) u_dr (
        .tck     (tck),
        .por_n   (por_n),
        .state_i (st),
        .sel_i   (sel),
        .tdi     (tdi),
        .pins_i  (pin_state),
        .lsb_o   (dr_lsb)
    );

    always_comb begin
        case (ir)
            OP_IDCODE:                           sel = SEL_ID;
            OP_ZERO_HIZ, OP_SAMPLE_Z, OP_SAMPLE: sel = SEL_BSR;
            default:                             sel = SEL_BYPASS;
        endcase
    end

    assign core_hiz = (ir == OP_ZERO_HIZ) || (ir == OP_SAMPLE_Z);

    // serial output is retimed to the falling edge
    always_ff @(negedge tck or negedge por_n) begin
        if (!por_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else if (st == TS_IR_SHIFT) begin
            tdo    <= ir_lsb;
            tdo_en <= 1'b1;
        end else if (st == TS_DR_SHIFT) begin
            tdo    <= dr_lsb;
            tdo_en <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end
    end

    // R10: at each rising edge the enable matches the shift states
    a_r10_en_in_shift: assert property (@(posedge tck) disable iff (!por_n)
        tdo_en == (st == TS_IR_SHIFT || st == TS_DR_SHIFT));

    // R5: output float starts only out of update-IR
    a_r5_hiz_from_update: assert property (@(posedge tck) disable iff (!por_n)
        $rose(core_hiz) |-> ($past(st) == TS_IR_UPD));

    // R9: update-DR does not move the output-disable line
    a_r9_hiz_stable_upd: assert property (@(posedge tck) disable iff (!por_n)
        (st == TS_DR_UPD) |=> $stable(core_hiz));

endmodule

// File: tb/tap_port_tb.sv
module tap_port_tb;

    localparam int N = 70;

    logic         tck = 1'b0;
    logic         por_n = 1'b0;
    logic         tms = 1'b1;
    logic         tdi = 1'b1;
    logic [N-1:0] pins;
    logic         tdo, tdo_en, core_hiz;

    always #4 tck = ~tck;

    tap_port u_dut (
        .tck       (tck),
        .por_n     (por_n),
        .tms       (tms),
        .tdi       (tdi),
        .pin_state (pins),
        .tdo       (tdo),
        .tdo_en    (tdo_en),
        .core_hiz  (core_hiz)
    );

    int   checks = 0;
    int   fails  = 0;
    logic s_tdo, s_en, s_hiz;
    logic sin  [0:127];
    logic sout [0:127];
    logic cap3 [0:2];
    logic hiz_in_upd, hiz_after;
    localparam logic [7:0]  MARK = 8'b1011_0001;
    localparam logic [31:0] ID_EXP = {4'd2, 5'd4, 5'd5, 6'd0, 11'h15A, 1'b1};

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        #2;
        s_tdo = tdo;
        s_en  = tdo_en;
        s_hiz = core_hiz;
        @(posedge tck);
        #1;
    endtask

    function automatic logic pin_val(input int i);
        return ((i * 5 + 3) % 7) < 3;
    endfunction

    function automatic logic bsr_exp(input int i);
        return (i == 36 || i == 51) ? 1'b1 : pins[i];
    endfunction

    // shift n bits from sin, ending in exit1, then update and idle
    task automatic shift_n(input int n);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, sin[i]);
            sout[i] = s_tdo;
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic to_shift_dr();
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
    endtask

    task automatic load_ir(input logic [2:0] code);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        tick(1'b0, 1'b0);
        for (int i = 0; i < 3; i++) begin
            tick(i == 2, code[i]);
            cap3[i] = s_tdo;
        end
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);
        hiz_in_upd = s_hiz;
        hiz_after  = core_hiz;
    endtask

    // kind: 0 bypass, 1 identification, 2 boundary
    task automatic dr_test(input int len, input int kind, input string req);
        int bad;
        logic e;
        bad = 0;
        to_shift_dr();
        for (int i = 0; i < len + 8; i++) sin[i] = (i < 8) ? MARK[i] : 1'b0;
        shift_n(len + 8);
        for (int i = 0; i < len; i++) begin
            e = (kind == 0) ? 1'b0 : (kind == 1) ? ID_EXP[i] : bsr_exp(i);
            if (sout[i] !== e) bad++;
        end
        chk(bad == 0, {req, " captured content"}, 64'(bad), 64'd0);
        bad = 0;
        for (int j = 0; j < 8; j++) if (sout[len + j] !== MARK[j]) bad++;
        chk(bad == 0, {req, " R11 length"}, 64'(bad), 64'd0);
    endtask

    function automatic int nxt(input int s, input logic m);
        case (s)
            0:  return m ? 0 : 1;
            1:  return m ? 2 : 1;
            2:  return m ? 9 : 3;
            3:  return m ? 5 : 4;
            4:  return m ? 5 : 4;
            5:  return m ? 8 : 6;
            6:  return m ? 7 : 6;
            7:  return m ? 8 : 4;
            8:  return m ? 2 : 1;
            9:  return m ? 0 : 10;
            10: return m ? 12 : 11;
            11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge tck);
        checks++;
        fails++;
        $display("FAIL R1 watchdog actual=timeout expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [2:0] codes [0:7];
        logic prev_hiz;
        logic exp_hiz;
        int len, kind;
        for (int i = 0; i < N; i++) pins[i] = pin_val(i);
        repeat (3) @(posedge tck);
        @(negedge tck);
        por_n = 1'b1;
        #2;
        chk(tdo_en == 1'b0, "R10 reset tdo_en", 64'(tdo_en), 64'd0);
        chk(tdo == 1'b0, "R10 reset tdo", 64'(tdo), 64'd0);
        chk(core_hiz == 1'b0, "R2 reset core_hiz", 64'(core_hiz), 64'd0);

        tick(1'b0, 1'b0);
        dr_test(32, 1, "R2 R7 power-up identification");

        // R10: no change at the rising edge, next bit after the falling edge
        to_shift_dr();
        tick(1'b0, 1'b0);
        chk(s_tdo == 1'b1, "R10 first id bit", 64'(s_tdo), 64'd1);
        chk(tdo == 1'b1, "R10 tdo held past rising edge", 64'(tdo), 64'd1);
        @(negedge tck);
        #1;
        chk(tdo == 1'b0, "R10 tdo after falling edge", 64'(tdo), 64'd0);
        tick(1'b1, 1'b0);
        tick(1'b1, 1'b0);
        tick(1'b0, 1'b0);

        codes = '{3'b111, 3'b100, 3'b000, 3'b010, 3'b011, 3'b101, 3'b110, 3'b001};
        prev_hiz = 1'b0;
        foreach (codes[k]) begin
            load_ir(codes[k]);
            chk(cap3[0] == 1'b1 && cap3[1] == 1'b0 && cap3[2] == 1'b0, "R3 capture-IR pattern",
                64'({cap3[2], cap3[1], cap3[0]}), 64'd1);
            chk(hiz_in_upd == prev_hiz, "R3 instruction waits for update", 64'(hiz_in_upd), 64'(prev_hiz));
            exp_hiz = (codes[k] == 3'b000) || (codes[k] == 3'b010);
            chk(hiz_after == exp_hiz, "R5 core_hiz per code", 64'(hiz_after), 64'(exp_hiz));
            prev_hiz = exp_hiz;
            if (codes[k] == 3'b001)      begin len = 32; kind = 1; end
            else if (codes[k] == 3'b000 || codes[k] == 3'b010 || codes[k] == 3'b100) begin len = N; kind = 2; end
            else                         begin len = 1;  kind = 0; end
            dr_test(len, kind, (kind == 0) ? "R4 R6 bypass path" : (kind == 1) ? "R4 R7 id path" : "R4 R8 boundary path");
        end

        // R9: update-DR under sample leaves no trace; fresh capture follows new pins
        load_ir(3'b100);
        to_shift_dr();
        for (int i = 0; i < N; i++) sin[i] = 1'b0;
        shift_n(N);
        chk(core_hiz == 1'b0, "R9 sample update-DR core_hiz", 64'(core_hiz), 64'd0);
        for (int i = 0; i < N; i++) pins[i] = ~pin_val(i);
        dr_test(N, 2, "R9 R8 recapture after update");

        load_ir(3'b010);
        to_shift_dr();
        shift_n(8);
        chk(core_hiz == 1'b1, "R9 sample-z update-DR core_hiz", 64'(core_hiz), 64'd1);

        // R2: reset by tms while a float instruction is active
        to_shift_dr();
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0);
        chk(s_en == 1'b0, "R2 left shift", 64'(s_en), 64'd0);
        tick(1'b1, 1'b0);
        chk(core_hiz == 1'b0, "R2 float released by reset", 64'(core_hiz), 64'd0);
        tick(1'b0, 1'b0);
        dr_test(32, 1, "R2 id after tms reset");

        // R1: pseudo-random walk over all transitions
        begin
            logic [15:0] lf;
            int cur, mism;
            bit hit [0:31];
            int missing;
            lf = 16'hACE1;
            cur = 1;
            mism = 0;
            foreach (hit[a]) hit[a] = 1'b0;
            for (int c = 0; c < 6000; c++) begin
                logic m;
                m = lf[0] ^ lf[3];
                tick(m, lf[7]);
                if (s_en !== (cur == 4 || cur == 11)) mism++;
                hit[cur * 2 + int'(m)] = 1'b1;
                cur = nxt(cur, m);
                lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            end
            chk(mism == 0, "R1 R10 enable follows state walk", 64'(mism), 64'd0);
            missing = 0;
            foreach (hit[a]) if (!hit[a]) missing++;
            chk(missing == 0, "R1 all transitions walked", 64'(missing), 64'd0);
        end
        for (int i = 0; i < 6; i++) tick(1'b1, 1'b0);
        chk(core_hiz == 1'b0, "R2 reset after walk", 64'(core_hiz), 64'd0);
        tick(1'b0, 1'b0);
        dr_test(32, 1, "R2 R7 id after walk");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule